// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Logic Target

This block loads a configuration image into a target programmable logic device over its slave-serial pins. A `start` pulse sets off a fixed sequence. The block switches on target power and waits for the supply to settle. It then holds the target's active-low program line low for a set time and releases it. Next it polls the target's initialisation-ready input. When that input is high, it shifts the image out one bit per configuration-clock pulse. After the last bit it keeps clocking until the target reports that configuration is done.

Image bytes arrive on a valid/ready stream, and `byte_last` marks the final byte. The block takes a byte only while it waits between bytes, never while it is shifting. In word-swap mode, which is sampled at `start`, each group of four bytes is sent in reverse order. Byte `i` of the image therefore goes out in position `i ^ 3`. Both the wait for the ready input and the wait for the done input have a limit. If either limit runs out, the run ends with `error` set. If configuration completes, the run ends with `success` set.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset the outputs are: `prog_n`=1, `cclk`=0, `din`=0, `power_en`=0, `busy`=0, `success`=0, `error`=0, `byte_ready`=0.
- R2: A `start` pulse sets `power_en` to 1. `power_en` stays 1 until reset. `prog_n` then stays high for exactly SETTLE_CYCLES clock cycles, with `busy` high.
- R3: After the settle interval, `prog_n` is low for exactly PROG_LOW_CYCLES cycles and then returns high. It stays high whenever `busy` is 0.
- R4: After `prog_n` rises, `init_sense` is sampled once per cycle. If INIT_POLL_MAX samples in a row read low, the run ends with `error`=1 and `cclk` never pulses.
- R5: Every image byte goes out MSB first with one `cclk` rising edge per bit. `din` is set up before the rising edge and stays unchanged while `cclk` is high.
- R6: The high and low phases of `cclk` each last `half_period` clock cycles. A `half_period` of 0 is treated as 1.
- R7: `byte_ready` is 1 only while the block waits for the next byte, and it is never 1 while `cclk` is high.
- R8: With `swap_words`=1 at start, the image goes out in byte order 3,2,1,0,7,6,5,4,… (index XOR 3).
- R9: In swap mode, if `byte_last` comes with a byte whose position is not a multiple of four minus one, the run ends with `error`=1. The bytes of that incomplete group never go out.
- R10: After the last data bit, the block issues further `cclk` pulses only while `done_sense` is low. It ends with `success`=1 once `done_sense` is high during a low phase.
- R11: If `done_sense` stays low for DONE_PULSE_MAX extra pulses, the run ends with `error`=1 after exactly that many extra pulses.
- R12: `busy` is 1 from start until the run ends. `success` and `error` are never both 1, neither is 1 while `busy` is 1, and they hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (taken when not busy) |
| swap_words | input | 1 | Reverse byte order inside each 4-byte group, sampled at start |
| half_period | input | DIV_W | System clocks per `cclk` phase (0 means 1) |
| byte_valid | input | 1 | Image byte offered |
| byte_data | input | 8 | Image byte |
| byte_last | input | 1 | Offered byte is the last of the image |
| byte_ready | output | 1 | Block takes the offered byte this cycle |
| init_sense | input | 1 | Target ready-for-data input (pulled up on board) |
| done_sense | input | 1 | Target configuration-done input (pulled up on board) |
| power_en | output | 1 | Target power enable |
| prog_n | output | 1 | Target program/reset, active low |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| busy | output | 1 | Run in progress |
| success | output | 1 | Last run completed with done seen |
| error | output | 1 | Last run ended on a timeout or a malformed swap-mode image |

## Verification
The hardest cases to reach are the two timeout endings. Each needs the target to stay silent for the full poll or pulse window, and the bench makes them reachable by using small limit parameters. A behavioural target model in the bench raises its ready input a set number of cycles after `prog_n` rises. It raises its done input after a chosen number of extra clock pulses beyond the image length. Giving either delay as negative makes the target stay silent. The bench then counts sampled polls and extra rising edges against the limits. The swap-mode length error is reached by ending a swap-mode image after three bytes. The bench then confirms that no clock pulse went out.

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader #(
  parameter int SETTLE_CYCLES   = 2400000,
  parameter int PROG_LOW_CYCLES = 2400000,
  parameter int INIT_POLL_MAX   = 100000,
  parameter int DONE_PULSE_MAX  = 100000,
  parameter int DIV_W           = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             swap_words,
  input  logic [DIV_W-1:0] half_period,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             byte_last,
  output logic             byte_ready,
  input  logic             init_sense,
  input  logic             done_sense,
  output logic             power_en,
  output logic             prog_n,
  output logic             cclk,
  output logic             din,
  output logic             busy,
  output logic             success,
  output logic             error
);
  localparam int M1 = (SETTLE_CYCLES > PROG_LOW_CYCLES) ? SETTLE_CYCLES : PROG_LOW_CYCLES;
  localparam int M2 = (INIT_POLL_MAX > DONE_PULSE_MAX) ? INIT_POLL_MAX : DONE_PULSE_MAX;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(CNT_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PROG, S_INIT, S_LOAD, S_SHIFT, S_FLUSH, S_OK, S_FAIL
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_idx;
  logic [1:0]       slot;
  logic [7:0]       grp [4];
  logic             last_seen, swap_r, cclk_r, din_r, pwr_r;

  logic [DIV_W-1:0] half;
  logic             phase_end;
  logic [1:0]       grp_top;

  assign half      = (half_period == '0) ? DIV_W'(1) : half_period;
  assign phase_end = (div_cnt == half - DIV_W'(1));
  assign grp_top   = swap_r ? 2'd3 : 2'd0;

  assign byte_ready = (st == S_LOAD);
  assign busy       = (st inside {S_PWR, S_PROG, S_INIT, S_LOAD, S_SHIFT, S_FLUSH});
  assign success    = (st == S_OK);
  assign error      = (st == S_FAIL);
  assign prog_n     = (st != S_PROG);
  assign power_en   = pwr_r;
  assign cclk       = cclk_r;
  assign din        = din_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      div_cnt   <= '0;
      bit_idx   <= '0;
      slot      <= '0;
      last_seen <= 1'b0;
      swap_r    <= 1'b0;
      cclk_r    <= 1'b0;
      din_r     <= 1'b0;
      pwr_r     <= 1'b0;
      for (int i = 0; i < 4; i++) grp[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_OK, S_FAIL: begin
          cclk_r <= 1'b0;
          din_r  <= 1'b0;
          if (start) begin
            st        <= S_PWR;
            cnt       <= '0;
            pwr_r     <= 1'b1;
            slot      <= '0;
            last_seen <= 1'b0;
            swap_r    <= swap_words;
          end
        end
        S_PWR: begin
          if (cnt == CW'(SETTLE_CYCLES - 1)) begin
            st  <= S_PROG;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PROG: begin
          if (cnt == CW'(PROG_LOW_CYCLES - 1)) begin
            st  <= S_INIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_INIT: begin
          if (init_sense) st <= S_LOAD;
          else if (cnt == CW'(INIT_POLL_MAX - 1)) st <= S_FAIL;
          else cnt <= cnt + 1'b1;
        end
        S_LOAD: begin
          if (byte_valid) begin
            grp[slot] <= byte_data;
            if (byte_last) last_seen <= 1'b1;
            if (slot == grp_top) begin
              st      <= S_SHIFT;
              bit_idx <= 3'd7;
              din_r   <= byte_data[7];
              div_cnt <= '0;
            end else if (byte_last) begin
              st <= S_FAIL;
            end else begin
              slot <= slot + 2'd1;
            end
          end
        end
        S_SHIFT: begin
          if (!phase_end) div_cnt <= div_cnt + 1'b1;
          else begin
            div_cnt <= '0;
            if (!cclk_r) cclk_r <= 1'b1;
            else begin
              cclk_r <= 1'b0;
              if (bit_idx != 3'd0) begin
                bit_idx <= bit_idx - 3'd1;
                din_r   <= grp[slot][bit_idx - 3'd1];
              end else if (slot != 2'd0) begin
                slot    <= slot - 2'd1;
                bit_idx <= 3'd7;
                din_r   <= grp[slot - 2'd1][7];
              end else begin
                din_r <= 1'b0;
                cnt   <= '0;
                st    <= last_seen ? S_FLUSH : S_LOAD;
              end
            end
          end
        end
        S_FLUSH: begin
          if (!cclk_r && done_sense) st <= S_OK;
          else if (!phase_end) div_cnt <= div_cnt + 1'b1;
          else begin
            div_cnt <= '0;
            if (!cclk_r) begin
              if (cnt == CW'(DONE_PULSE_MAX)) st <= S_FAIL;
              else cclk_r <= 1'b1;
            end else begin
              cclk_r <= 1'b0;
              cnt    <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_serial_loader_chk.sv
module fpga_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic cclk,
  input logic din,
  input logic byte_ready,
  input logic busy,
  input logic success,
  input logic error,
  input logic prog_n,
  input logic power_en
);
  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |-> !byte_ready);

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && error));

  // R12
  flags_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!success && !error));

  // R3
  prog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> prog_n);

  // R5
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din));

  // R2
  power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(power_en) |-> power_en);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cclk && !din));
endmodule

bind fpga_serial_loader fpga_serial_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cclk(cclk), .din(din), .byte_ready(byte_ready),
  .busy(busy), .success(success), .error(error), .prog_n(prog_n), .power_en(power_en)
);

// File: tb/fpga_serial_loader_tb_top.sv
module fpga_serial_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 12;
  localparam int PLOW   = 7;
  localparam int IPOLL  = 40;
  localparam int DPULSE = 25;
  localparam int DW     = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, swap_words = 1'b0;
  logic [DW-1:0] half_period = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, init_drv, done_drv;
  logic power_en, prog_n, cclk, din, busy, success, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_serial_loader #(
    .SETTLE_CYCLES(SETTLE), .PROG_LOW_CYCLES(PLOW),
    .INIT_POLL_MAX(IPOLL), .DONE_PULSE_MAX(DPULSE), .DIV_W(DW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .swap_words(swap_words),
    .half_period(half_period), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .byte_ready(byte_ready), .init_sense(init_drv),
    .done_sense(done_drv), .power_en(power_en), .prog_n(prog_n), .cclk(cclk),
    .din(din), .busy(busy), .success(success), .error(error)
  );

  int checks = 0, errors = 0, cycles = 0;
  int init_delay, init_tmr, done_extra, nbytes, ncap;
  int n_settle, n_prog, n_poll, hi_run, hi_min, hi_max;
  bit prog_seen, ready_bad, hold_bad, prev_cclk, prev_din;
  logic [7:0] img [16];
  logic       cap [256];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
    if (rst_n) begin
      if (busy && prog_n && !prog_seen) n_settle++;
      if (!prog_n) n_prog++;
      if (busy && prog_seen && prog_n && !init_drv) n_poll++;
      if (!prog_n) begin prog_seen = 1; init_tmr = 0; init_drv = 0; end
      else if (prog_seen && init_delay >= 0) begin
        if (init_tmr >= init_delay) init_drv = 1; else init_tmr++;
      end
      if (cclk && byte_ready) ready_bad = 1;
      if (cclk && prev_cclk && din != prev_din) hold_bad = 1;
      if (cclk) hi_run++;
      else if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      prev_cclk = cclk; prev_din = din;
    end
  end

  always @(posedge cclk) begin
    if (ncap < 256) cap[ncap] = din;
    ncap++;
    if (done_extra >= 0 && ncap == 8*nbytes + done_extra) done_drv = 1;
  end

  task automatic do_reset(input int idly, input int dext, input int n);
    rst_n = 0; start = 0; byte_valid = 0; byte_last = 0;
    init_drv = 0; done_drv = 0; init_delay = idly; init_tmr = 0;
    done_extra = dext; nbytes = n; ncap = 0;
    n_settle = 0; n_prog = 0; n_poll = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
    prog_seen = 0; ready_bad = 0; hold_bad = 0; prev_cclk = 0; prev_din = 0;
    if (dext == 0 && n == 0) done_drv = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic kick(input bit sw, input int hp);
    swap_words = sw; half_period = DW'(hp); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic feed(input int n, input int last_at);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = img[i]; byte_last = (i == last_at);
      for (int w = 0; w < 5000 && !byte_ready; w++) @(negedge clk);
      @(negedge clk);
    end
    byte_valid = 0; byte_last = 0;
  endtask

  task automatic wait_end();
    for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
  endtask

  task automatic check_order(input string req, input int n, input bit sw);
    for (int k = 0; k < n; k++) begin
      logic [7:0] got;
      for (int b = 0; b < 8; b++) got[7-b] = cap[8*k+b];
      check(req, int'(got), int'(img[sw ? (k ^ 3) : k]));
    end
  endtask

  task automatic t_reset();
    do_reset(0, -1, 0);
    check("R1 prog_n", int'(prog_n), 1);
    check("R1 cclk/din", int'({cclk, din}), 0);
    check("R1 power/busy/flags", int'({power_en, busy, success, error, byte_ready}), 0);
  endtask

  task automatic t_plain();
    img[0] = 8'hA5; img[1] = 8'h3C; img[2] = 8'h01; img[3] = 8'h80;
    do_reset(5, 3, 4);
    kick(0, 2);
    check("R2 power_en on", int'(power_en), 1);
    check("R12 busy on", int'(busy), 1);
    feed(4, 3);
    wait_end();
    check("R2 settle cycles", n_settle, SETTLE);
    check("R3 prog low cycles", n_prog, PLOW);
    check("R3 prog_n released", int'(prog_n), 1);
    check_order("R5 msb first", 4, 0);
    check("R5 din held while high", int'(hold_bad), 0);
    check("R6 high min", hi_min, 2);
    check("R6 high max", hi_max, 2);
    check("R7 ready quiet", int'(ready_bad), 0);
    check("R10 extra pulses", ncap, 32 + 3);
    check("R10 success", int'(success), 1);
    check("R12 flags", int'({busy, error}), 0);
    check("R2 power held", int'(power_en), 1);
  endtask

  task automatic t_swap();
    for (int i = 0; i < 8; i++) img[i] = 8'(8'h10 * i + i + 1);
    do_reset(0, 0, 8);
    kick(1, 0);
    feed(8, 7);
    wait_end();
    check_order("R8 xor3 order", 8, 1);
    check("R6 half zero width", hi_max, 1);
    check("R10 no extra pulse", ncap, 64);
    check("R10 success swap", int'(success), 1);
  endtask

  task automatic t_init_to();
    do_reset(-1, -1, 0);
    kick(0, 1);
    wait_end();
    check("R4 polls", n_poll, IPOLL);
    check("R4 error", int'(error), 1);
    check("R4 no cclk", ncap, 0);
    check("R12 no success", int'(success), 0);
  endtask

  task automatic t_done_to();
    img[0] = 8'hC3; img[1] = 8'h5A;
    do_reset(2, -1, 2);
    kick(0, 1);
    feed(2, 1);
    wait_end();
    check("R11 pulses", ncap, 16 + DPULSE);
    check("R11 error", int'(error), 1);
    check("R12 excl", int'(success), 0);
  endtask

  task automatic t_bad_len();
    img[0] = 8'h11; img[1] = 8'h22; img[2] = 8'h33;
    do_reset(1, 0, 3);
    kick(1, 1);
    feed(3, 2);
    wait_end();
    check("R9 error", int'(error), 1);
    check("R9 no cclk", ncap, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_swap();
    t_init_to();
    t_done_to();
    t_bad_len();
    finish_run();
  end
endmodule